// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Engine

This block is the slave side of a two-wire serial memory. It sits behind a pair of bus pins and in front of a small byte-wide array, modelled here as an inferable RAM. A fast system clock oversamples the bus lines, and start and stop conditions are found in that clock domain. The block decodes the device-select byte and keeps a word pointer. That one pointer serves both reads and writes. Data bytes are moved between the bus and the array.

Writes go straight into the array, one byte for each acknowledged data byte. When the stop arrives, a one-cycle pulse hands the page off to an external write-cycle block. That block then holds the busy input high while it programs. During that time the engine refuses to acknowledge its own address, so a bus master can poll for completion. Reads return the byte at the pointer and advance it. A write that carries only a word address and is followed by a repeated start gives a random read. Acknowledged reads continue through the whole array. A write-protect input turns the array read-only, while the address phases are still acknowledged.

Top module: `i2c_ee_slave`

## Requirements
- R1: After reset the SDA pull-down enable `sda_oe` and the hand-off pulse `wr_start_o` are both low.
- R2: The address byte is acknowledged only when its bits [7:4] equal `DEV_ID` (default 4'hA) and those of its bits [3:1] that are not array-address bits match `dev_pins`. With the default 9-bit array, bits [3:2] are compared against `dev_pins[2:1]`. Any other address gets no acknowledge, and the engine ignores the bus until the next start.
- R3: In a write, bit 0 of the address byte is 0. The second byte loads the low 8 pointer bits. Each data byte after it is acknowledged and stored at the pointer. A stop that follows at least one stored byte produces exactly one single-cycle `wr_start_o` pulse.
- R4: While `wr_busy_i` is high, the engine does not acknowledge its own address. Once `wr_busy_i` is low again, it acknowledges.
- R5: With `wp_i` high, the address byte and the word byte are acknowledged. The first data byte is not acknowledged and not stored, and no `wr_start_o` pulse follows.
- R6: During a write, the pointer advances only within its 16-byte page: the low 4 bits wrap and the bits above them stay fixed.
- R7: A read with no word address returns the byte at the pointer. After any access to address n, that pointer is n+1, subject to the page wrap of R6 for writes.
- R8: A repeated start after the word byte, followed by an address byte with bit 0 set, reads from the newly loaded address.
- R9: Each master acknowledge after a read byte makes the engine send the next byte. The read pointer wraps from the last array address to 0.
- R10: After a master no-acknowledge, the engine releases SDA. It drives nothing on further clocks until a start or stop.
- R11: The engine changes its SDA drive only some cycles after SCL has fallen, and never in the first system clock after the fall.
- R12: For arrays larger than 256 bytes, the low address-byte select bits supply the upper array address bits, so addresses that differ only in those bits are separate locations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe | output | 1 | When high, the data line is pulled low |
| dev_pins | input | 3 | Hard-wired device select straps |
| wp_i | input | 1 | Write protect, high blocks array writes |
| wr_busy_i | input | 1 | High while the external write cycle runs |
| wr_start_o | output | 1 | One-cycle pulse asking for a write cycle |

## Verification
The engine reacts to bus edges only after the two synchronizer flops, the three-sample majority filter and the edge register. It then waits `HOLD` more cycles before changing `sda_oe`, so an acknowledge or data bit appears about ten system clocks after SCL falls. The bench therefore samples the line in the middle of the following SCL-high phase, with 10 system clocks of margin on each side. It checks directly that `sda_oe` is still low one cycle after the eighth falling edge. The `wr_start_o` pulse comes one cycle after the filtered stop. The bench counts pulses on the falling system clock edge and compares the count two bus quarter-periods after the stop. Busy polling depends on the bench's own write-cycle model, which holds `wr_busy_i` high for a fixed 1500 cycles.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVSEL,
    ST_WORD,
    ST_WDATA,
    ST_ACK,
    ST_TX,
    ST_TXACK,
    ST_WAIT_STOP
  } ee_state_t;

endpackage

// File: rtl/i2c_ee_glitch.sv
module i2c_ee_glitch #(
  parameter int SAMPLES = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic q
);

  logic [1:0]         sync_r;
  logic [SAMPLES-1:0] hist_r;
  int                 ones;

  always_comb begin
    ones = 0;
    for (int i = 0; i < SAMPLES; i++) ones = ones + int'(hist_r[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_r <= 2'b11;
      hist_r <= '1;
      q      <= 1'b1;
    end else begin
      sync_r <= {sync_r[0], din};
      hist_r <= {hist_r[SAMPLES-2:0], sync_r[1]};
      q      <= (ones > SAMPLES / 2);
    end
  end

endmodule

// File: rtl/i2c_ee_ram.sv
module i2c_ee_ram #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) cells[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end

endmodule

// File: rtl/i2c_ee_slave.sv
module i2c_ee_slave #(
  parameter int         MEM_AW  = 9,
  parameter logic [3:0] DEV_ID  = 4'hA,
  parameter int         FILT    = 3,
  parameter int         HOLD    = 4,
  parameter int         PAGE_AW = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] dev_pins,
  input  logic       wp_i,
  input  logic       wr_busy_i,
  output logic       wr_start_o
);
  import i2c_ee_pkg::*;

  localparam int         UPW      = MEM_AW - 8;
  localparam logic [2:0] SEL_MASK = 3'(3'b111 << UPW);
  localparam int         HOLD_W   = $clog2(HOLD + 1);

  // Filtered bus lines: index 0 is SCL, index 1 is SDA.
  logic [1:0] raw_lines;
  logic [1:0] filt_lines;
  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2c_ee_glitch #(.SAMPLES(FILT)) u_filt (
      .clk (clk),
      .rst (rst),
      .din (raw_lines[g]),
      .q   (filt_lines[g])
    );
  end

  logic s_scl, s_sda, p_scl, p_sda;
  assign s_scl = filt_lines[0];
  assign s_sda = filt_lines[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      p_scl <= 1'b1;
      p_sda <= 1'b1;
    end else begin
      p_scl <= s_scl;
      p_sda <= s_sda;
    end
  end

  logic start_ev, stop_ev, scl_rise, scl_fall;
  assign start_ev = s_scl & p_scl & p_sda & ~s_sda;
  assign stop_ev  = s_scl & p_scl & ~p_sda & s_sda;
  assign scl_rise = s_scl & ~p_scl;
  assign scl_fall = ~s_scl & p_scl;

  ee_state_t         state, ack_next;
  logic [3:0]        bitcnt;
  logic [7:0]        shreg, txreg;
  logic [MEM_AW-1:0] ptr, ptr_sel, ptr_word, ptr_page_inc;
  logic              drv_want, wrote, mack;
  logic              mem_we;
  logic [MEM_AW-1:0] mem_wa;
  logic [7:0]        mem_wd, mem_rd;
  logic [HOLD_W-1:0] hold_cnt;
  logic              sda_oe_r, wr_start_r;

  // Pointer variants: select bits on top, word byte below, page increment.
  if (UPW > 0) begin : g_up
    assign ptr_sel  = {shreg[UPW:1], ptr[7:0]};
    assign ptr_word = {ptr[MEM_AW-1:8], shreg};
  end else begin : g_noup
    assign ptr_sel  = ptr;
    assign ptr_word = shreg;
  end
  assign ptr_page_inc = {ptr[MEM_AW-1:PAGE_AW], ptr[PAGE_AW-1:0] + 1'b1};

  logic byte_done, devsel_eval, wdata_eval, addr_hit;
  assign byte_done   = scl_fall && (bitcnt == 4'd8) && !start_ev && !stop_ev;
  assign devsel_eval = byte_done && (state == ST_DEVSEL);
  assign wdata_eval  = byte_done && (state == ST_WDATA);
  assign addr_hit    = (shreg[7:4] == DEV_ID) &&
                       (((shreg[3:1] ^ dev_pins) & SEL_MASK) == 3'b000) &&
                       !wr_busy_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      ack_next   <= ST_IDLE;
      bitcnt     <= '0;
      shreg      <= '0;
      txreg      <= '0;
      ptr        <= '0;
      drv_want   <= 1'b0;
      wrote      <= 1'b0;
      mack       <= 1'b0;
      mem_we     <= 1'b0;
      mem_wa     <= '0;
      mem_wd     <= '0;
      wr_start_r <= 1'b0;
    end else begin
      mem_we     <= 1'b0;
      wr_start_r <= 1'b0;
      if (start_ev) begin
        state    <= ST_DEVSEL;
        bitcnt   <= '0;
        drv_want <= 1'b0;
      end else if (stop_ev) begin
        state    <= ST_IDLE;
        drv_want <= 1'b0;
        if (wrote) begin
          wr_start_r <= 1'b1;
          wrote      <= 1'b0;
        end
      end else begin
        case (state)
          ST_DEVSEL, ST_WORD, ST_WDATA: begin
            if (scl_rise) begin
              shreg  <= {shreg[6:0], s_sda};
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_done) begin
              bitcnt <= '0;
              if (state == ST_DEVSEL) begin
                if (addr_hit) begin
                  drv_want <= 1'b1;
                  ptr      <= ptr_sel;
                  ack_next <= shreg[0] ? ST_TX : ST_WORD;
                  state    <= ST_ACK;
                end else begin
                  drv_want <= 1'b0;
                  state    <= ST_IDLE;
                end
              end else if (state == ST_WORD) begin
                ptr      <= ptr_word;
                drv_want <= 1'b1;
                ack_next <= ST_WDATA;
                state    <= ST_ACK;
              end else if (wp_i) begin
                drv_want <= 1'b0;
                state    <= ST_WAIT_STOP;
              end else begin
                mem_we   <= 1'b1;
                mem_wa   <= ptr;
                mem_wd   <= shreg;
                ptr      <= ptr_page_inc;
                wrote    <= 1'b1;
                drv_want <= 1'b1;
                ack_next <= ST_WDATA;
                state    <= ST_ACK;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              state  <= ack_next;
              bitcnt <= '0;
              if (ack_next == ST_TX) begin
                txreg    <= mem_rd;
                drv_want <= ~mem_rd[7];
                bitcnt   <= 4'd1;
                ptr      <= ptr + 1'b1;
              end else begin
                drv_want <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                drv_want <= 1'b0;
                state    <= ST_TXACK;
              end else begin
                txreg    <= {txreg[6:0], 1'b0};
                drv_want <= ~txreg[6];
                bitcnt   <= bitcnt + 4'd1;
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) begin
              mack <= ~s_sda;
            end else if (scl_fall) begin
              if (mack) begin
                txreg    <= mem_rd;
                drv_want <= ~mem_rd[7];
                bitcnt   <= 4'd1;
                ptr      <= ptr + 1'b1;
                state    <= ST_TX;
              end else begin
                state <= ST_WAIT_STOP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // SDA drive follows drv_want only after HOLD cycles of low SCL.
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cnt <= '0;
      sda_oe_r <= 1'b0;
    end else if (start_ev || stop_ev) begin
      hold_cnt <= '0;
      sda_oe_r <= 1'b0;
    end else if (scl_fall) begin
      hold_cnt <= HOLD_W'(HOLD);
    end else if (hold_cnt != '0) begin
      hold_cnt <= hold_cnt - 1'b1;
    end else begin
      sda_oe_r <= drv_want;
    end
  end

  i2c_ee_ram #(.AW(MEM_AW), .DW(8)) u_ram (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_wa),
    .wdata (mem_wd),
    .raddr (ptr),
    .rdata (mem_rd)
  );

  assign sda_oe     = sda_oe_r;
  assign wr_start_o = wr_start_r;

endmodule

// File: rtl/i2c_ee_slave_chk.sv
module i2c_ee_slave_chk
  import i2c_ee_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      s_scl,
  input logic      sda_oe,
  input logic      wr_start_o,
  input logic      wr_busy_i,
  input logic      wp_i,
  input logic      stop_ev,
  input logic      devsel_eval,
  input logic      wdata_eval,
  input logic      drv_want,
  input ee_state_t state
);

  // R3: the hand-off pulse is one cycle wide.
  a_r3_pulse_single: assert property (@(posedge clk) disable iff (rst)
    wr_start_o |=> !wr_start_o);

  // R3: the hand-off only follows a stop condition.
  a_r3_after_stop: assert property (@(posedge clk) disable iff (rst)
    wr_start_o |-> $past(stop_ev));

  // R4: no acknowledge to the address while the write cycle is busy.
  a_r4_busy_nack: assert property (@(posedge clk) disable iff (rst)
    (devsel_eval && wr_busy_i) |=> (!drv_want && state == ST_IDLE));

  // R5: protected data bytes are not acknowledged.
  a_r5_wp_nack: assert property (@(posedge clk) disable iff (rst)
    (wdata_eval && wp_i) |=> (!drv_want && state == ST_WAIT_STOP));

  // R10: after a no-acknowledge the line stays released.
  a_r10_released: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_STOP) |-> !sda_oe);

  // R11: the pull-down only turns on while SCL is low.
  a_r11_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !s_scl);

endmodule

bind i2c_ee_slave i2c_ee_slave_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .s_scl       (s_scl),
  .sda_oe      (sda_oe),
  .wr_start_o  (wr_start_o),
  .wr_busy_i   (wr_busy_i),
  .wp_i        (wp_i),
  .stop_ev     (stop_ev),
  .devsel_eval (devsel_eval),
  .wdata_eval  (wdata_eval),
  .drv_want    (drv_want),
  .state       (state)
);

// File: tb/i2c_ee_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_ee_slave_tb_top;

  localparam int Q    = 10;
  localparam int BUSY = 1500;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       wp = 1'b0;
  logic       busy;
  logic [2:0] pins = 3'b101;
  logic       sda_oe, wr_start_o;
  wire        sda_line = sda_m & ~sda_oe;

  int busy_cnt = 0;
  int pulses   = 0;
  int vectors  = 0;
  int miscompares = 0;
  bit finished = 0;

  logic [7:0] mdl_mem [512];
  logic [8:0] mdl_ptr;
  logic [7:0] dbuf [32];

  always #2 clk = ~clk;

  i2c_ee_slave dut_i (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .sda_oe     (sda_oe),
    .dev_pins   (pins),
    .wp_i       (wp),
    .wr_busy_i  (busy),
    .wr_start_o (wr_start_o)
  );

  // Bench model of the external write-cycle block.
  always @(negedge clk) begin
    if (rst) busy_cnt <= 0;
    else if (wr_start_o) begin
      busy_cnt <= BUSY;
      pulses   <= pulses + 1;
    end else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
  end
  assign busy = (busy_cnt != 0);

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  function automatic logic [7:0] dsel(input logic [8:0] a, input bit rd);
    return {4'hA, pins[2:1], a[8], rd};
  endfunction

  task automatic i2c_start();
    sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(2);
    sda_m = 1'b0; wq(2); scl_m = 1'b0; wq(1);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(1); scl_m = 1'b1; wq(2);
    sda_m = 1'b1; wq(2);
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(1); scl_m = 1'b1; wq(2); scl_m = 1'b0;
      if (i == 0) begin
        @(negedge clk);
        chk("R11 no drive right after fall", int'(sda_oe), 0);
        repeat (Q - 1) @(negedge clk);
      end else wq(1);
    end
    sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1);
    ack = ~sda_line; wq(1); scl_m = 1'b0; wq(1);
  endtask

  task automatic rbyte(input bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wq(1); scl_m = 1'b1; wq(1);
      b[i] = sda_line; wq(1); scl_m = 1'b0; wq(1);
    end
    sda_m = ~give_ack; wq(1); scl_m = 1'b1; wq(2); scl_m = 1'b0; wq(1);
    sda_m = 1'b1;
  endtask

  task automatic wait_idle();
    while (busy_cnt != 0) @(negedge clk);
    repeat (10) @(negedge clk);
  endtask

  // Write n bytes from dbuf at address a; checks acks and hand-off pulse.
  task automatic ee_write(input logic [8:0] a, input int n, input string req);
    bit ack;
    int p0;
    logic [8:0] wa;
    p0 = pulses;
    i2c_start();
    wbyte(dsel(a, 1'b0), ack); chk({req, " devsel ack"}, int'(ack), 1);
    wbyte(a[7:0], ack);        chk({req, " word ack"}, int'(ack), 1);
    wa = a;
    for (int i = 0; i < n; i++) begin
      wbyte(dbuf[i], ack);
      chk({req, " data ack"}, int'(ack), 1);
      mdl_mem[wa] = dbuf[i];
      wa = {wa[8:4], wa[3:0] + 4'd1};
    end
    mdl_ptr = wa;
    i2c_stop();
    wq(2);
    chk("R3 one hand-off pulse", pulses - p0, 1);
    wait_idle();
  endtask

  task automatic read_tail(input int n, input string req);
    logic [7:0] b;
    for (int i = 0; i < n; i++) begin
      rbyte(i != n - 1, b);
      chk(req, int'(b), int'(mdl_mem[mdl_ptr]));
      mdl_ptr = mdl_ptr + 9'd1;
    end
    wq(1);
    chk("R10 released after nack", int'(sda_oe), 0);
    i2c_stop();
  endtask

  task automatic ee_rand_read(input logic [8:0] a, input int n, input string req);
    bit ack;
    i2c_start();
    wbyte(dsel(a, 1'b0), ack); chk({req, " devsel ack"}, int'(ack), 1);
    wbyte(a[7:0], ack);        chk({req, " word ack"}, int'(ack), 1);
    i2c_start();
    wbyte(dsel(a, 1'b1), ack); chk({req, " read devsel ack"}, int'(ack), 1);
    mdl_ptr = a;
    read_tail(n, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    report();
  end

  initial begin
    bit ack;
    int polls;
    int p0;
    logic [7:0] b;
    logic [8:0] a;
    for (int i = 0; i < 512; i++) mdl_mem[i] = 8'h00;
    mdl_ptr = '0;
    void'($urandom(32'd1234));
    repeat (10) @(negedge clk);
    chk("R1 sda_oe in reset", int'(sda_oe), 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 sda_oe after reset", int'(sda_oe), 0);
    chk("R1 wr_start_o after reset", int'(wr_start_o), 0);

    // R2: wrong identifier, then wrong strap bits.
    i2c_start();
    wbyte({4'h5, pins[2:1], 2'b00}, ack); chk("R2 bad id nack", int'(ack), 0);
    wbyte(8'h00, ack); chk("R2 ignored until start", int'(ack), 0);
    i2c_stop();
    i2c_start();
    wbyte({4'hA, ~pins[2:1], 2'b00}, ack); chk("R2 bad strap nack", int'(ack), 0);
    i2c_stop();

    // R3 / R12: byte writes to locations that differ only in bit 8.
    dbuf[0] = 8'h3C; ee_write(9'h105, 1, "R3 byte write");
    dbuf[0] = 8'hC3;
    p0 = pulses;
    i2c_start();
    wbyte(dsel(9'h005, 1'b0), ack); chk("R12 devsel", int'(ack), 1);
    wbyte(8'h05, ack); wbyte(dbuf[0], ack);
    chk("R3 data ack", int'(ack), 1);
    mdl_mem[9'h005] = 8'hC3; mdl_ptr = 9'h006;
    i2c_stop();

    // R4: poll while the write cycle runs.
    polls = 0;
    ack = 0;
    while (!ack && polls < 10) begin
      i2c_start();
      wbyte(dsel(9'h000, 1'b0), ack);
      if (polls == 0) chk("R4 nack while busy", int'(ack), 0);
      i2c_stop();
      polls++;
    end
    chk("R4 ack after busy", int'(ack), 1);
    chk("R3 single pulse", pulses - p0, 1);
    wait_idle();

    ee_rand_read(9'h105, 1, "R8 random read");
    ee_rand_read(9'h005, 1, "R12 upper select bit");

    // R7: current-address read continues at n+1.
    i2c_start();
    wbyte(dsel(mdl_ptr, 1'b1), ack); chk("R7 devsel ack", int'(ack), 1);
    read_tail(1, "R7 current read");

    // R6: page write of 20 bytes from page offset 8.
    for (int i = 0; i < 20; i++) dbuf[i] = 8'($urandom);
    ee_write(9'h0E8, 20, "R6 page write");
    i2c_start();
    wbyte(dsel(mdl_ptr, 1'b1), ack); chk("R7 devsel after write", int'(ack), 1);
    read_tail(1, "R7 read after page write");
    ee_rand_read(9'h0E0, 16, "R6 page contents");

    // R5: write protect.
    wp = 1'b1;
    p0 = pulses;
    i2c_start();
    wbyte(dsel(9'h0E2, 1'b0), ack); chk("R5 devsel ack", int'(ack), 1);
    wbyte(8'hE2, ack);              chk("R5 word ack", int'(ack), 1);
    wbyte(~mdl_mem[9'h0E2], ack);   chk("R5 data nack", int'(ack), 0);
    i2c_stop();
    wq(2);
    chk("R5 no hand-off", pulses - p0, 0);
    wp = 1'b0;
    ee_rand_read(9'h0E2, 1, "R5 data unchanged");

    // R9: sequential read wraps at the end of the array.
    dbuf[0] = 8'hA5; dbuf[1] = 8'h5A; ee_write(9'h1FE, 2, "R9 setup");
    dbuf[0] = 8'h77; ee_write(9'h000, 1, "R9 setup");
    ee_rand_read(9'h1FE, 4, "R9 sequential wrap");

    // R10: clocks after a no-acknowledge are ignored.
    i2c_start();
    wbyte(dsel(9'h100, 1'b1), ack);
    mdl_ptr = {1'b1, mdl_ptr[7:0]};
    rbyte(1'b0, b);
    chk("R9 first byte", int'(b), int'(mdl_mem[mdl_ptr]));
    rbyte(1'b0, b);
    chk("R10 line idle after nack", int'(b), 8'hFF);
    i2c_stop();
    mdl_ptr = mdl_ptr + 9'd1;

    // Constrained random writes and read-backs.
    for (int k = 0; k < 6; k++) begin
      int n;
      a = 9'($urandom % 512);
      n = 1 + int'($urandom % 3);
      for (int i = 0; i < n; i++) dbuf[i] = 8'($urandom);
      ee_write(a, n, "R3 random write");
      ee_rand_read(a, n, "R9 random read-back");
    end

    report();
  end

endmodule